// File: doc/BRIEF.md
# FPR High-Half Transfer Unit

This unit owns a 32-entry array of 64-bit floating-point registers. It carries out two transfers between an integer operand and the upper half of a floating-point register. One reads the high half out to the integer side, sign-extended. The other writes the low word of an integer source into that high half. A mode input selects the register layout. In wide layout every entry holds a full 64-bit value. In narrow layout each entry holds one 32-bit word, and an even/odd register pair forms a 64-bit value whose high word sits in the odd partner.

A transfer is presented as a valid strobe together with a 32-bit instruction word. An integer source and the mode bit accompany the strobe. A read-out result appears one clock later on a registered result port, with a write enable and the destination integer register number. When narrow layout is used with an odd register number, the unit does not trap. It returns or stores fixed poison words and raises a one-cycle warning. A combinational debug port exposes any array entry.

Top module: `fpr_hi_xfer`

## Requirements
- R1: After synchronous reset, res_we and warn_odd are 0, and every array entry reads as zero on the debug port.
- R2: A transfer is accepted only when xfer_valid is 1, bits 31:26 are 010001 and bits 10:0 are zero. Bits 25:21 must equal 00011 (read high) or 00111 (write high). The destination integer register is bits 20:16 and the floating register fs is bits 15:11.
- R3: Wide layout (wide_mode=1), read high: one cycle after acceptance, res_we=1, res_reg=rt and res_data is bits 63:32 of entry fs, sign-extended to 64 bits.
- R4: Wide layout, write high: entry fs becomes {int_src[31:0], old bits 31:0}. No result is produced.
- R5: Narrow layout (wide_mode=0) with even fs, read high: res_data is bits 31:0 of entry fs+1, sign-extended.
- R6: Narrow layout with even fs, write high: entry fs+1 becomes {32'h0, int_src[31:0]}. Entry fs is unchanged.
- R7: Narrow layout with odd fs, read high: res_data is 64'h0000_0000_0BAD_F00D.
- R8: Narrow layout with odd fs, write high: entry fs itself becomes 64'h0000_0000_DEAD_C0DE.
- R9: warn_odd is 1 for exactly the one cycle after an accepted narrow-layout transfer with odd fs. It is 0 after every other cycle.
- R10: A cycle without an accepted transfer (strobe low, wrong major opcode, wrong bits 25:21, or nonzero bits 10:0) produces no result, no warning and no array change.
- R11: An array write takes effect at the clock edge that accepts it. A transfer in the very next cycle, and the debug port, observe the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_valid | input | 1 | Transfer strobe |
| xfer_insn | input | 32 | Instruction word |
| int_src | input | 64 | Integer source operand |
| wide_mode | input | 1 | 1 = 64-bit entries, 0 = paired 32-bit entries |
| res_we | output | 1 | Integer result valid / write enable |
| res_reg | output | 5 | Destination integer register number |
| res_data | output | 64 | Integer result |
| warn_odd | output | 1 | Odd register used in narrow layout |
| dbg_idx | input | 5 | Debug read index |
| dbg_data | output | 64 | Debug read data |

## Verification
The bench focuses on the pairing rule: narrow-layout transfers with even fs must reach fs+1. A design that used fs would corrupt the low word of the pair and read back the wrong half. Odd register numbers in narrow layout are driven on purpose. A design that forwarded them normally would return live data instead of the poison word, or write the wrong entry, or miss the warning. Back-to-back write-then-read pairs to the same entry expose a design that reads stale data. Encodings with stray low bits or a wrong sub-field show whether a design acts on malformed words, which would appear as spurious results or array changes.

// File: rtl/fht_pkg.sv
package fht_pkg;

    localparam int DATA_W   = 64;
    localparam int HALF_W   = DATA_W / 2;
    localparam int IDX_W    = 5;
    localparam int NREG     = 1 << IDX_W;

    localparam logic [5:0] MAJOR_OP  = 6'b010001;
    localparam logic [4:0] SUB_RDHI  = 5'b00011;
    localparam logic [4:0] SUB_WRHI  = 5'b00111;

    localparam logic [HALF_W-1:0] POISON_RD = 32'h0BAD_F00D;
    localparam logic [HALF_W-1:0] POISON_WR = 32'hDEAD_C0DE;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RDHI = 2'd1,
        OP_WRHI = 2'd2
    } xfer_op_e;

    typedef struct packed {
        xfer_op_e             op;
        logic [IDX_W-1:0]     rt;
        logic [IDX_W-1:0]     fs;
    } xfer_dec_t;

    function automatic logic [DATA_W-1:0] sext_half(input logic [HALF_W-1:0] w);
        return {{HALF_W{w[HALF_W-1]}}, w};
    endfunction

endpackage

// File: rtl/fht_decode.sv
module fht_decode
    import fht_pkg::*;
(
    input  logic        valid,
    input  logic [31:0] insn,
    output xfer_dec_t   dec
);
    logic base_ok;

    always_comb begin
        base_ok = valid && (insn[31:26] == MAJOR_OP) && (insn[10:0] == 11'd0);
        dec.rt  = insn[20:16];
        dec.fs  = insn[15:11];
        dec.op  = OP_NONE;
        if (base_ok) begin
            if (insn[25:21] == SUB_RDHI)      dec.op = OP_RDHI;
            else if (insn[25:21] == SUB_WRHI) dec.op = OP_WRHI;
        end
    end
endmodule

// File: rtl/fht_regfile.sv
module fht_regfile
    import fht_pkg::*;
#(
    parameter int N_ENT = NREG,
    parameter int W     = DATA_W,
    localparam int AW   = $clog2(N_ENT)
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [W-1:0]  rd_data,
    input  logic [AW-1:0] dbg_idx,
    output logic [W-1:0]  dbg_data
);
    logic [W-1:0]     ent [N_ENT];
    logic [N_ENT-1:0] row_we;

    for (genvar i = 0; i < N_ENT; i++) begin : g_row
        assign row_we[i] = wr_en && (wr_idx == AW'(i));
        always_ff @(posedge clk) begin
            if (rst)            ent[i] <= '0;
            else if (row_we[i]) ent[i] <= wr_data;
        end
    end

    assign rd_data  = ent[rd_idx];
    assign dbg_data = ent[dbg_idx];

    // R11: a single row is written per accepted transfer
    a_r11_single_row: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_we));

    // R11: the written value is readable at the next cycle
    a_r11_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ent[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/fpr_hi_xfer.sv
module fpr_hi_xfer
    import fht_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_valid,
    input  logic [31:0]       xfer_insn,
    input  logic [DATA_W-1:0] int_src,
    input  logic              wide_mode,
    output logic              res_we,
    output logic [IDX_W-1:0]  res_reg,
    output logic [DATA_W-1:0] res_data,
    output logic              warn_odd,
    input  logic [IDX_W-1:0]  dbg_idx,
    output logic [DATA_W-1:0] dbg_data
);
    xfer_dec_t         dec;
    logic              odd_narrow;
    logic [IDX_W-1:0]  tgt_idx;
    logic [DATA_W-1:0] tgt_data;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_value;

    fht_decode u_dec (
        .valid (xfer_valid),
        .insn  (xfer_insn),
        .dec   (dec)
    );

    fht_regfile #(.N_ENT(NREG), .W(DATA_W)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (tgt_idx),
        .wr_data  (wr_data),
        .rd_idx   (tgt_idx),
        .rd_data  (tgt_data),
        .dbg_idx  (dbg_idx),
        .dbg_data (dbg_data)
    );

    always_comb begin
        odd_narrow = !wide_mode && dec.fs[0];
        tgt_idx    = (!wide_mode && !dec.fs[0]) ? (dec.fs | IDX_W'(1)) : dec.fs;
        wr_en      = (dec.op == OP_WRHI);
        if (wide_mode) begin
            rd_value = sext_half(tgt_data[DATA_W-1:HALF_W]);
            wr_data  = {int_src[HALF_W-1:0], tgt_data[HALF_W-1:0]};
        end else if (odd_narrow) begin
            rd_value = sext_half(POISON_RD);
            wr_data  = {{HALF_W{1'b0}}, POISON_WR};
        end else begin
            rd_value = sext_half(tgt_data[HALF_W-1:0]);
            wr_data  = {{HALF_W{1'b0}}, int_src[HALF_W-1:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_we   <= 1'b0;
            res_reg  <= '0;
            res_data <= '0;
            warn_odd <= 1'b0;
        end else begin
            res_we   <= (dec.op == OP_RDHI);
            warn_odd <= (dec.op != OP_NONE) && odd_narrow;
            if (dec.op == OP_RDHI) begin
                res_reg  <= dec.rt;
                res_data <= rd_value;
            end
        end
    end

    // R10: no result without a strobe in the previous cycle
    a_r10_result_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        res_we |-> $past(xfer_valid));

    // R10: no array write without a strobe
    a_r10_write_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> xfer_valid);

    // R9: warning only follows a narrow-layout strobe
    a_r9_warn_narrow_only: assert property (@(posedge clk) disable iff (rst)
        warn_odd |-> $past(xfer_valid && !wide_mode));

    // R7: a poisoned read returns the fixed word
    a_r7_poison_read: assert property (@(posedge clk) disable iff (rst)
        (res_we && warn_odd) |-> (res_data == 64'h0000_0000_0BAD_F00D));

    // R3: result upper half is always a sign extension
    a_r3_sign_extended: assert property (@(posedge clk) disable iff (rst)
        res_we |-> (res_data[DATA_W-1:HALF_W] == {HALF_W{res_data[HALF_W-1]}}));
endmodule

// File: tb/test_fpr_hi_xfer.sv
module test_fpr_hi_xfer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xfer_valid = 1'b0;
    logic [31:0] xfer_insn = '0;
    logic [63:0] int_src = '0;
    logic        wide_mode = 1'b1;
    logic        res_we;
    logic [4:0]  res_reg;
    logic [63:0] res_data;
    logic        warn_odd;
    logic [4:0]  dbg_idx = '0;
    logic [63:0] dbg_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [63:0] mdl [32];

    always #10 clk = ~clk;

    fpr_hi_xfer i_fpr_hi_xfer (
        .clk(clk), .rst(rst), .xfer_valid(xfer_valid), .xfer_insn(xfer_insn),
        .int_src(int_src), .wide_mode(wide_mode), .res_we(res_we),
        .res_reg(res_reg), .res_data(res_data), .warn_odd(warn_odd),
        .dbg_idx(dbg_idx), .dbg_data(dbg_data)
    );

    function automatic logic [31:0] mk(input logic [4:0] sub, input logic [4:0] rt,
                                       input logic [4:0] fs);
        return {6'b010001, sub, rt, fs, 11'd0};
    endfunction

    function automatic logic [63:0] sx(input logic [31:0] w);
        return {{32{w[31]}}, w};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a negedge; drives one cycle and checks outputs at the next negedge.
    task automatic step(input bit v, input logic [31:0] insn, input logic [63:0] src,
                        input bit wide, input string tag);
        bit ok_enc, rd, wr, odd;
        logic [4:0] fs, tgt;
        logic [63:0] e_data;
        xfer_valid = v; xfer_insn = insn; int_src = src; wide_mode = wide;
        ok_enc = v && insn[31:26] == 6'b010001 && insn[10:0] == 11'd0;
        rd  = ok_enc && insn[25:21] == 5'b00011;
        wr  = ok_enc && insn[25:21] == 5'b00111;
        fs  = insn[15:11];
        odd = !wide && fs[0];
        tgt = (!wide && !fs[0]) ? (fs | 5'd1) : fs;
        e_data = '0;
        if (rd) begin
            if (wide)     e_data = sx(mdl[tgt][63:32]);
            else if (odd) e_data = 64'h0000_0000_0BAD_F00D;
            else          e_data = sx(mdl[tgt][31:0]);
        end
        @(posedge clk);
        if (wr) begin
            if (wide)     mdl[tgt] = {src[31:0], mdl[tgt][31:0]};
            else if (odd) mdl[tgt] = 64'h0000_0000_DEAD_C0DE;
            else          mdl[tgt] = {32'h0, src[31:0]};
        end
        @(negedge clk);
        chk(res_we == rd, {tag, " R10 res_we"}, 64'(res_we), 64'(rd));
        if (rd) begin
            chk(res_data == e_data, {tag, " data"}, res_data, e_data);
            chk(res_reg == insn[20:16], {tag, " R2 res_reg"}, 64'(res_reg), 64'(insn[20:16]));
        end
        chk(warn_odd == ((rd || wr) && odd), {tag, " R9 warn"}, 64'(warn_odd),
            64'((rd || wr) && odd));
        if (wr) begin
            dbg_idx = tgt; #1;
            chk(dbg_data == mdl[tgt], {tag, " write"}, dbg_data, mdl[tgt]);
        end
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 32; i++) begin
            dbg_idx = 5'(i); #1;
            chk(dbg_data == mdl[i], tag, dbg_data, mdl[i]);
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(res_we == 0 && warn_odd == 0, "R1 reset outputs", 64'({res_we, warn_odd}), 0);
        sweep("R1 reset array");

        // Directed corner cases
        step(1, mk(5'b00111, 0, 4), 64'hFFFF_FFFF_1234_5678, 1, "R4 wide write");
        step(1, mk(5'b00011, 9, 4), 0, 1, "R3 R11 wide read back-to-back");
        step(1, mk(5'b00111, 0, 6), 64'h0000_0000_8765_4321, 0, "R6 narrow even write");
        step(1, mk(5'b00011, 3, 6), 0, 0, "R5 R11 narrow even read neg");
        step(1, mk(5'b00111, 0, 7), 64'h1, 0, "R8 narrow odd write");
        step(1, mk(5'b00011, 2, 7), 0, 0, "R7 narrow odd read");
        step(0, 0, 0, 0, "R9 warn drops");
        step(1, mk(5'b00011, 1, 31), 0, 1, "R9 wide odd no warn");
        step(1, mk(5'b00111, 0, 8) | 32'h1, 64'hAAAA, 1, "R10 low bits");
        step(1, {6'b010000, 5'b00111, 5'd0, 5'd8, 11'd0}, 64'hBBBB, 1, "R10 opcode");
        step(1, mk(5'b00101, 0, 8), 64'hCCCC, 1, "R10 subfield");
        step(0, mk(5'b00111, 0, 8), 64'hDDDD, 1, "R10 no strobe");
        sweep("R10 array untouched");

        // Constrained random mix
        void'($urandom(32'd1234));
        for (int k = 0; k < 400; k++) begin
            logic [4:0] sub;
            logic [31:0] ins;
            int r = $urandom_range(0, 9);
            sub = (r < 5) ? 5'b00011 : (r < 9) ? 5'b00111 : 5'($urandom);
            ins = mk(sub, 5'($urandom), 5'($urandom_range(0, 7)));
            if ($urandom_range(0, 19) == 0) ins[10:0] = 11'($urandom);
            step($urandom_range(0, 7) != 0, ins, {$urandom, $urandom},
                 $urandom_range(0, 1) == 1, "R3 R4 R5 R6 random");
        end
        sweep("R11 final array");

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule